// File: doc/BRIEF.md
# ADC Hardware-Trigger Conversion Sequencer

This block is the digital control for an analog-to-digital converter that samples one selected channel per conversion, and only when a hardware trigger asks for it. Software controls it through three register-write strobes: an enable bit, a start/busy bit and a channel-select field. An external trigger pulse starts each conversion. The block sends a one-cycle start strobe and a channel number to the converter. The converter later returns a done pulse, a result word and the channel the result belongs to. When a completion is accepted, the block stores the word in a result register and raises a one-cycle end-of-conversion interrupt.

A conversion that is in flight can be disturbed in three ways: by a new trigger, by a new channel write, or by writing 1 to the start bit. Each of these cancels the conversion at once and starts a fresh one. Writing 0 to the start bit cancels the conversion and puts the block back into trigger standby. Clearing the enable bit cancels the conversion and stops the block. Whenever a conversion is cancelled, the converter receives a one-cycle abort strobe. The abort strobe and the result-acceptance rule together ensure that a completion from a cancelled conversion can never be stored.

The control is a three-state machine. ST_STOP is the idle, disabled state. ST_STANDBY is enabled and waiting for a trigger. ST_CONV means a conversion is in flight. The transitions are:
- T_ENABLE: ST_STOP to ST_STANDBY.
- T_DISABLE: any state to ST_STOP.
- T_TRIGGER: ST_STANDBY to ST_CONV.
- T_RESTART: ST_CONV to ST_CONV.
- T_HALT: ST_CONV to ST_STANDBY.
- T_COMPLETE: ST_CONV to ST_STANDBY.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, the block is in ST_STOP. `enabled`, `busy`, `conv_start`, `conv_abort` and `eoc_irq` are 0, and `conv_ch` and `result` are 0.
- R2: A write of 1 to the enable bit while stopped moves the block to standby: `enabled`=1 and `busy`=0. No start strobe is issued.
- R3: In standby, a `hw_trig` pulse sets `busy` to 1. In the next cycle it issues a one-cycle `conv_start`, with `conv_ch` equal to the selected channel.
- R4: In ST_CONV, a `conv_done` whose tag equals `conv_ch` does three things. In the next cycle, `result` holds the returned word and `eoc_irq` is 1 for exactly one cycle. In that same cycle `busy` clears. No further conversion starts until another trigger arrives.
- R5: A `hw_trig` during a conversion drives `conv_abort` and `conv_start` together for one cycle, on the same channel. `busy` stays 1, and only one interrupt follows.
- R6: A channel write during a conversion restarts the conversion on the newly written channel, driving `conv_abort` and `conv_start` together.
- R7: A write of 1 to the start bit during a conversion restarts it in the same way as R5.
- R8: A write of 0 to the start bit during a conversion returns the block to standby. It drives `conv_abort` without `conv_start`, issues no interrupt, and leaves `result` unchanged.
- R9: While the enable bit is 0, `hw_trig` is ignored: no `conv_start` and `busy` stays 0.
- R10: Clearing the enable bit during a conversion aborts it and enters ST_STOP, with no interrupt. This event takes priority over any trigger or write in the same cycle.
- R11: A `conv_done` is dropped, with no interrupt and `result` unchanged, in three cases: its tag differs from `conv_ch`, it arrives outside ST_CONV, or it coincides with an abort or restart event.
- R12: A write of 1 to the start bit while not converting has no effect: no `conv_start` and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| go_we | input | 1 | Write strobe for the start/busy bit |
| go_wdata | input | 1 | Value written to the start/busy bit |
| ch_we | input | 1 | Write strobe for the channel-select field |
| ch_wdata | input | CH_W | Channel value written |
| hw_trig | input | 1 | Hardware trigger pulse |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | DATA_W | Converter result word |
| conv_tag | input | CH_W | Channel the converter's result belongs to |
| enabled | output | 1 | Enable bit readback (not ST_STOP) |
| busy | output | 1 | Start/busy bit readback (ST_CONV) |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_abort | output | 1 | One-cycle abort strobe to the converter |
| conv_ch | output | CH_W | Selected channel, driven to the converter |
| result | output | DATA_W | Last accepted conversion result |
| eoc_irq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The assertions assume that the write strobes and the trigger are synchronous single-cycle pulses. They also assume that the converter drives `conv_done` for one cycle, with its data and tag valid in that same cycle. The bench drives every stimulus on the falling edge, as a one-cycle pulse. Its converter model returns a word computed from the tag after a fixed latency, and restarts or clears on the start and abort strobes. Stale or mismatched completions come only from a separate injection path that drives exactly one done cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_STANDBY = 2'd1,
        ST_CONV    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_seq_cmd.sv
module adc_seq_cmd #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we,
    input  logic            en_wdata,
    input  logic            go_we,
    input  logic            go_wdata,
    input  logic            ch_we,
    input  logic [CH_W-1:0] ch_wdata,
    input  logic            hw_trig,
    output logic            ev_enable,
    output logic            ev_disable,
    output logic            ev_halt,
    output logic            ev_trig,
    output logic            ev_restart,
    output logic [CH_W-1:0] ch_sel
);
    // Channel-select register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ch_sel <= '0;
        else if (ch_we)
            ch_sel <= ch_wdata;
    end

    // Decode the write strobes into sequencer events
    always_comb begin
        ev_enable  = en_we & en_wdata;
        ev_disable = en_we & ~en_wdata;
        ev_halt    = go_we & ~go_wdata;
        ev_trig    = hw_trig;
        ev_restart = hw_trig | (go_we & go_wdata) | ch_we;
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_enable,
    input  logic            ev_disable,
    input  logic            ev_halt,
    input  logic            ev_trig,
    input  logic            ev_restart,
    input  logic            conv_done,
    input  logic [CH_W-1:0] conv_tag,
    input  logic [CH_W-1:0] ch_sel,
    output logic            accept,
    output logic            conv_start,
    output logic            conv_abort,
    output logic            enabled,
    output logic            busy
);
    seq_state_t state_q, state_d;
    logic       start_d, abort_d;
    logic       tag_ok;

    assign tag_ok = (conv_tag == ch_sel);

    // State register and registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_STOP;
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
        end else begin
            state_q    <= state_d;
            conv_start <= start_d;
            conv_abort <= abort_d;
        end
    end

    // Next state and strobe decisions
    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        abort_d = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                if (ev_enable)                   // T_ENABLE
                    state_d = ST_STANDBY;
            end
            ST_STANDBY: begin
                if (ev_disable)                  // T_DISABLE
                    state_d = ST_STOP;
                else if (ev_trig) begin          // T_TRIGGER
                    state_d = ST_CONV;
                    start_d = 1'b1;
                end
            end
            ST_CONV: begin
                if (ev_disable) begin            // T_DISABLE
                    state_d = ST_STOP;
                    abort_d = 1'b1;
                end else if (ev_halt) begin      // T_HALT
                    state_d = ST_STANDBY;
                    abort_d = 1'b1;
                end else if (ev_restart) begin   // T_RESTART
                    abort_d = 1'b1;
                    start_d = 1'b1;
                end else if (conv_done && tag_ok) begin  // T_COMPLETE
                    state_d = ST_STANDBY;
                    accept  = 1'b1;
                end
            end
            default: state_d = ST_STOP;
        endcase
    end

    assign enabled = (state_q != ST_STOP);
    assign busy    = (state_q == ST_CONV);

    AST_STOP_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && ev_trig) |=> !conv_start); // R9
    AST_RESTART_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && ev_restart && !ev_halt && !ev_disable) |=> (conv_start && conv_abort && busy)); // R5
    AST_HALT_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && ev_halt && !ev_disable) |=> (enabled && !busy && conv_abort && !conv_start)); // R8
    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && ev_disable) |=> (!enabled && conv_abort && !conv_start)); // R10
    AST_IDLE_DONE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CONV && conv_done) |-> !accept); // R11
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] result,
    output logic              eoc_irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            eoc_irq <= 1'b0;
        end else begin
            eoc_irq <= accept;
            if (accept)
                result <= conv_data;
        end
    end

    AST_LATCH_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (eoc_irq && result == $past(conv_data))); // R4
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(result)); // R11
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
    parameter int CH_W   = 3,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              en_wdata,
    input  logic              go_we,
    input  logic              go_wdata,
    input  logic              ch_we,
    input  logic [CH_W-1:0]   ch_wdata,
    input  logic              hw_trig,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [CH_W-1:0]   conv_tag,
    output logic              enabled,
    output logic              busy,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [CH_W-1:0]   conv_ch,
    output logic [DATA_W-1:0] result,
    output logic              eoc_irq
);
    logic ev_enable, ev_disable, ev_halt, ev_trig, ev_restart;
    logic accept;

    adc_seq_cmd #(.CH_W(CH_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .go_we      (go_we),
        .go_wdata   (go_wdata),
        .ch_we      (ch_we),
        .ch_wdata   (ch_wdata),
        .hw_trig    (hw_trig),
        .ev_enable  (ev_enable),
        .ev_disable (ev_disable),
        .ev_halt    (ev_halt),
        .ev_trig    (ev_trig),
        .ev_restart (ev_restart),
        .ch_sel     (conv_ch)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_enable  (ev_enable),
        .ev_disable (ev_disable),
        .ev_halt    (ev_halt),
        .ev_trig    (ev_trig),
        .ev_restart (ev_restart),
        .conv_done  (conv_done),
        .conv_tag   (conv_tag),
        .ch_sel     (conv_ch),
        .accept     (accept),
        .conv_start (conv_start),
        .conv_abort (conv_abort),
        .enabled    (enabled),
        .busy       (busy)
    );

    adc_seq_result #(.DATA_W(DATA_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .conv_data (conv_data),
        .result    (result),
        .eoc_irq   (eoc_irq)
    );

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R3
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq); // R4
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> (!busy && enabled)); // R4
    AST_TAG_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && conv_tag != conv_ch) |=> !eoc_irq); // R11
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> (!conv_start && !busy)); // R9
endmodule

// File: tb/tb_adc_trig_seq.sv
module tb_adc_trig_seq;
    localparam int CH_W   = 3;
    localparam int DATA_W = 12;
    localparam int LAT    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_we = 0, en_wdata = 0, go_we = 0, go_wdata = 0, ch_we = 0, hw_trig = 0;
    logic [CH_W-1:0] ch_wdata = '0;
    logic conv_done;
    logic [DATA_W-1:0] conv_data;
    logic [CH_W-1:0] conv_tag;
    logic enabled, busy, conv_start, conv_abort, eoc_irq;
    logic [CH_W-1:0] conv_ch;
    logic [DATA_W-1:0] result;

    // converter model and injection path
    int unsigned cnt = 0;
    logic [CH_W-1:0] mtag = '0;
    logic mdone = 1'b0;
    logic inj = 1'b0;
    logic [CH_W-1:0] inj_tag = '0;

    int checks = 0, errors = 0;
    int n_start = 0, n_abort = 0, n_eoc = 0;

    always #2 clk = ~clk;

    function automatic logic [DATA_W-1:0] expv(int ch);
        return DATA_W'(ch * 97 + 5);
    endfunction

    assign conv_done = mdone | inj;
    assign conv_tag  = inj ? inj_tag : mtag;
    assign conv_data = inj ? DATA_W'(12'hABC) : expv(int'(mtag));

    always @(posedge clk) begin
        mdone <= 1'b0;
        if (!rst_n) begin
            cnt <= 0;
        end else if (conv_start) begin
            cnt  <= LAT;
            mtag <= conv_ch;
        end else if (conv_abort) begin
            cnt <= 0;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) mdone <= 1'b1;
        end
        if (rst_n) begin
            if (conv_start) n_start++;
            if (conv_abort) n_abort++;
            if (eoc_irq)    n_eoc++;
        end
    end

    adc_trig_seq #(.CH_W(CH_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .en_we(en_we), .en_wdata(en_wdata), .go_we(go_we), .go_wdata(go_wdata),
        .ch_we(ch_we), .ch_wdata(ch_wdata), .hw_trig(hw_trig),
        .conv_done(conv_done), .conv_data(conv_data), .conv_tag(conv_tag),
        .enabled(enabled), .busy(busy), .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_ch(conv_ch), .result(result), .eoc_irq(eoc_irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr_in();
        en_we = 0; go_we = 0; ch_we = 0; hw_trig = 0; inj = 0;
    endtask

    task automatic wr_en(logic v);
        en_we = 1; en_wdata = v; tick(1); clr_in();
    endtask
    task automatic wr_go(logic v);
        go_we = 1; go_wdata = v; tick(1); clr_in();
    endtask
    task automatic wr_ch(int c);
        ch_we = 1; ch_wdata = CH_W'(c); tick(1); clr_in();
    endtask
    task automatic trig();
        hw_trig = 1; tick(1); clr_in();
    endtask

    // wait for one interrupt, up to a limit; returns 1 if seen
    task automatic wait_eoc(output bit seen);
        seen = 0;
        for (int i = 0; i < 3 * LAT; i++) begin
            if (eoc_irq) begin seen = 1; break; end
            tick(1);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        bit seen;
        int e0, s0, a0;
        logic [DATA_W-1:0] r0;
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1 enabled", int'(enabled), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 strobes", int'(conv_start | conv_abort | eoc_irq), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 conv_ch", int'(conv_ch), 0);

        // R9 trigger ignored while disabled
        s0 = n_start;
        trig(); tick(LAT + 4);
        chk("R9 no start", n_start - s0, 0);
        chk("R9 busy", int'(busy), 0);
        // R12 go=1 while stopped
        wr_go(1); tick(3);
        chk("R12 stopped no start", n_start - s0, 0);

        // R2 enable
        wr_en(1);
        chk("R2 enabled", int'(enabled), 1);
        chk("R2 busy", int'(busy), 0);
        tick(3);
        chk("R2 no start", n_start - s0, 0);
        // R12 go=1 in standby
        wr_go(1); tick(3);
        chk("R12 standby no start", n_start - s0, 0);
        chk("R12 busy", int'(busy), 0);

        // R3/R4 sweep every channel
        for (int c = 0; c < (1 << CH_W); c++) begin
            wr_ch(c);
            e0 = n_eoc; s0 = n_start;
            trig();
            chk("R3 busy", int'(busy), 1);
            chk("R3 start", int'(conv_start), 1);
            chk("R3 channel", int'(conv_ch), c);
            wait_eoc(seen);
            chk("R4 eoc seen", int'(seen), 1);
            chk("R4 result", int'(result), int'(expv(c)));
            chk("R4 busy clear", int'(busy), 0);
            tick(1);
            chk("R4 one cycle", int'(eoc_irq), 0);
            tick(3 * LAT);
            chk("R4 single irq", n_eoc - e0, 1);
            chk("R4 no auto restart", n_start - s0, 1);
        end

        // R5 trigger during conversion
        wr_ch(3);
        e0 = n_eoc; a0 = n_abort;
        trig(); tick(3);
        trig();
        chk("R5 pair", int'(conv_start & conv_abort), 1);
        chk("R5 same ch", int'(conv_ch), 3);
        chk("R5 busy", int'(busy), 1);
        tick(3 * LAT);
        chk("R5 one irq", n_eoc - e0, 1);
        chk("R5 abort count", n_abort - a0, 1);
        chk("R5 result", int'(result), int'(expv(3)));

        // R6 channel rewrite during conversion
        wr_ch(2);
        e0 = n_eoc;
        trig(); tick(2);
        wr_ch(5);
        chk("R6 pair", int'(conv_start & conv_abort), 1);
        chk("R6 new ch", int'(conv_ch), 5);
        tick(3 * LAT);
        chk("R6 one irq", n_eoc - e0, 1);
        chk("R6 result", int'(result), int'(expv(5)));

        // R7 go=1 during conversion
        wr_ch(6);
        e0 = n_eoc; a0 = n_abort;
        trig(); tick(LAT - 1);
        wr_go(1);
        chk("R7 pair", int'(conv_start & conv_abort), 1);
        tick(3 * LAT);
        chk("R7 one irq", n_eoc - e0, 1);
        chk("R7 abort count", n_abort - a0, 1);
        chk("R7 result", int'(result), int'(expv(6)));

        // R8 go=0 during conversion
        wr_ch(1);
        e0 = n_eoc; r0 = result; s0 = n_start;
        trig(); tick(2);
        wr_go(0);
        chk("R8 abort only", int'({conv_abort, conv_start}), 2);
        chk("R8 busy", int'(busy), 0);
        chk("R8 enabled", int'(enabled), 1);
        tick(3 * LAT);
        chk("R8 no irq", n_eoc - e0, 0);
        chk("R8 result held", int'(result), int'(r0));
        trig();
        chk("R8 standby retrigger", n_start - s0, 1);
        tick(3 * LAT);
        chk("R8 later result", int'(result), int'(expv(1)));

        // R10 disable during conversion, with simultaneous trigger
        e0 = n_eoc; r0 = result;
        trig(); tick(2);
        en_we = 1; en_wdata = 0; hw_trig = 1; tick(1); clr_in();
        chk("R10 abort only", int'({conv_abort, conv_start}), 2);
        chk("R10 enabled", int'(enabled), 0);
        tick(3 * LAT);
        chk("R10 no irq", n_eoc - e0, 0);
        chk("R10 result held", int'(result), int'(r0));
        chk("R9 busy after disable", int'(busy), 0);

        // R11 stale completions
        wr_en(1);
        wr_ch(4);
        e0 = n_eoc; r0 = result;
        inj = 1; inj_tag = 3'd4; tick(1); clr_in(); tick(2);
        chk("R11 idle done", n_eoc - e0, 0);
        trig(); tick(1);
        inj = 1; inj_tag = 3'd2; tick(1); clr_in(); tick(1);
        chk("R11 tag mismatch", n_eoc - e0, 0);
        chk("R11 still busy", int'(busy), 1);
        chk("R11 held", int'(result), int'(r0));
        tick(3 * LAT);
        chk("R11 real one", n_eoc - e0, 1);
        chk("R11 result", int'(result), int'(expv(4)));
        // done coinciding with a restart
        e0 = n_eoc;
        trig(); tick(1);
        inj = 1; inj_tag = 3'd4; hw_trig = 1; tick(1); clr_in(); tick(1);
        chk("R11 coincident dropped", n_eoc - e0, 0);
        tick(3 * LAT);
        chk("R11 restart completes", n_eoc - e0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule